// File: doc/BRIEF.md
# CRC and Data Reorder Unit

This block is a bus-fed data helper. Each cycle it may accept one data word of one, two or four bytes. For every accepted word it does two things. It registers a reordered copy of the word, built from optional bit inversion, bit reversal and byte swapping, together with an even parity bit over a selectable range. It also folds the same raw word into a running CRC. The CRC uses one of four fixed generators, which have 8, 16, 16 and 32 bits.

Software loads a seed value before a message. The seed is kept, so a later init pulse can restart the CRC from it. The CRC result is offered at a port masked to the width of the chosen generator, and it can be bit-reversed within that width. The input side uses a valid/ready pair. Ready never drops, so a DMA engine can stream one word per clock.

Top module: `crc_reorder_unit`

## Requirements
- R1: While reset is asserted, `out_data` and `out_parity` are 0, and the CRC register and the stored seed hold the `RESET_SEED` parameter (default all ones).
- R2: `in_ready` is 1 in every cycle, including during reset.
- R3: A word is accepted when `in_valid` is 1. Its data range is picked by `in_size`: 0 uses `in_data[7:0]`, 1 uses `in_data[15:0]`, and 2 or 3 use `in_data[31:0]`. The bits enter the CRC most significant first, all in that one clock. The generator is picked by `cfg_poly`: 0 gives 8-bit 0x07, 1 gives 16-bit 0x8005, 2 gives 16-bit 0x1021, and 3 gives 32-bit 0x04C11DB7. No final XOR is applied.
- R4: A cycle with `seed_wr` high stores `seed_data` as the seed and loads it into the CRC register. This takes priority over `crc_init` and over any word accepted in that cycle.
- R5: A cycle with `crc_init` high and `seed_wr` low reloads the CRC register from the stored seed. Any word accepted in that cycle does not reach the CRC.
- R6: `crc_out` shows the CRC register masked to the generator width, with the bits above that width reading zero. When `cfg_crc_rev` is 1, the low width bits are shown in reversed order.
- R7: `out_data` is updated one cycle after a word is accepted. The word is first inverted when `cfg_invert` is 1. It is then bit-reversed according to `cfg_bitrev`: 0 means no reversal, 1 reverses within each byte, 2 reverses within each 16-bit half, and 3 reverses the whole 32-bit word.
- R8: After the bit reversal, `cfg_swap` selects a byte order. 0 or 3 means no swap. 1 swaps the two bytes of each 16-bit half. 2 reverses the order of all four bytes.
- R9: `out_parity` is updated one cycle after a word is accepted. It is the XOR of the raw `in_data` bits in the range picked by `cfg_par_range`: 0 uses bits 7:0, 1 uses bits 15:0, and 2 or 3 use bits 31:0.
- R10: In a cycle with `in_valid` low, `out_data` and `out_parity` keep their values. If `seed_wr` and `crc_init` are also low, the CRC register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input ready, always high |
| in_data | input | 32 | Input data word |
| in_size | input | 2 | Byte count code of the word |
| cfg_poly | input | 2 | CRC generator select |
| cfg_crc_rev | input | 1 | Reverse CRC result bits within the width |
| cfg_invert | input | 1 | Invert data before reordering |
| cfg_bitrev | input | 2 | Bit reversal span select |
| cfg_swap | input | 2 | Byte order select |
| cfg_par_range | input | 2 | Parity range select |
| seed_wr | input | 1 | Store and load a new seed |
| seed_data | input | 32 | Seed value |
| crc_init | input | 1 | Reload CRC from the stored seed |
| out_data | output | 32 | Reordered data, registered |
| out_parity | output | 1 | Even parity of the raw word, registered |
| crc_out | output | 32 | Formatted CRC result |

## Verification
A CRC register that goes wrong stays wrong. Because every later word is folded into it, the error shows up on `crc_out` in the cycle after the word that caused it, and it persists until the next seed load or init pulse. For that reason every cycle of the randomized run is compared against a bit-serial reference, and known check values are used for the 8-, 16- and 32-bit generators. Errors in the reorder path or the parity path last only one word. They show up one cycle after acceptance, so directed patterns cover every mode code of those paths.

// File: rtl/crcru_pkg.sv
package crcru_pkg;

   typedef enum logic [1:0] {
      POLY_CRC8  = 2'd0,
      POLY_CRC16 = 2'd1,
      POLY_CCITT = 2'd2,
      POLY_CRC32 = 2'd3
   } crcru_poly_e;

   typedef enum logic [1:0] {
      REV_NONE = 2'd0,
      REV_BYTE = 2'd1,
      REV_HALF = 2'd2,
      REV_WORD = 2'd3
   } crcru_rev_e;

   typedef enum logic [1:0] {
      SWP_NONE = 2'd0,
      SWP_HALF = 2'd1,
      SWP_WORD = 2'd2,
      SWP_KEEP = 2'd3
   } crcru_swap_e;

   localparam int unsigned CRC_MAX_W = 32;

   function automatic int unsigned poly_width(input logic [1:0] sel);
      case (crcru_poly_e'(sel))
         POLY_CRC8:  return 8;
         POLY_CRC16: return 16;
         POLY_CCITT: return 16;
         default:    return 32;
      endcase
   endfunction

   function automatic logic [31:0] poly_value(input logic [1:0] sel);
      case (crcru_poly_e'(sel))
         POLY_CRC8:  return 32'h0000_0007;
         POLY_CRC16: return 32'h0000_8005;
         POLY_CCITT: return 32'h0000_1021;
         default:    return 32'h04C1_1DB7;
      endcase
   endfunction

   function automatic logic [31:0] width_mask(input int unsigned w);
      if (w >= 32) return 32'hFFFF_FFFF;
      return (32'd1 << w) - 32'd1;
   endfunction

   function automatic int unsigned size_bits(input logic [1:0] sz);
      case (sz)
         2'd0:    return 8;
         2'd1:    return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/crcru_reorder.sv
module crcru_reorder
   import crcru_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] din,
   input  logic              invert,
   input  logic [1:0]        bitrev,
   input  logic [1:0]        swap,
   output logic [WORD_W-1:0] dout
);
   localparam int unsigned BYTES = WORD_W / 8;

   if (WORD_W % 32 != 0) begin : g_bad_width
      $error("crcru_reorder: WORD_W must be a multiple of 32");
   end

   logic [WORD_W-1:0] inv_d;
   logic [WORD_W-1:0] rv_byte, rv_half, rv_word;
   logic [WORD_W-1:0] rv_sel;
   logic [WORD_W-1:0] sw_half, sw_word;

   assign inv_d = invert ? ~din : din;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign rv_byte[i] = inv_d[(i / 8) * 8 + 7 - (i % 8)];
      assign rv_half[i] = inv_d[(i / 16) * 16 + 15 - (i % 16)];
      assign rv_word[i] = inv_d[(i / 32) * 32 + 31 - (i % 32)];
   end

   always_comb begin
      case (crcru_rev_e'(bitrev))
         REV_BYTE: rv_sel = rv_byte;
         REV_HALF: rv_sel = rv_half;
         REV_WORD: rv_sel = rv_word;
         default:  rv_sel = inv_d;
      endcase
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign sw_half[b*8 +: 8] = rv_sel[(b ^ 1) * 8 +: 8];
      assign sw_word[b*8 +: 8] = rv_sel[((b / 4) * 4 + 3 - (b % 4)) * 8 +: 8];
   end

   always_comb begin
      case (crcru_swap_e'(swap))
         SWP_HALF: dout = sw_half;
         SWP_WORD: dout = sw_word;
         default:  dout = rv_sel;
      endcase
   end

   always_comb begin
      if (!invert && bitrev == 2'd0 && (swap == 2'd0 || swap == 2'd3))
         a_passthrough_r7 : assert (dout == din);
   end

endmodule

// File: rtl/crcru_parity.sv
module crcru_parity #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] din,
   input  logic [1:0]        range_sel,
   output logic              par
);
   if (WORD_W < 32) begin : g_bad_width
      $error("crcru_parity: WORD_W must be at least 32");
   end

   always_comb begin
      case (range_sel)
         2'd0:    par = ^din[7:0];
         2'd1:    par = ^din[15:0];
         default: par = ^din[31:0];
      endcase
   end

endmodule

// File: rtl/crcru_crc_engine.sv
module crcru_crc_engine
   import crcru_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter logic [31:0] RESET_SEED = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [WORD_W-1:0] data,
   input  logic [1:0]        size,
   input  logic [1:0]        poly,
   input  logic              load,
   input  logic [31:0]       load_val,
   output logic [31:0]       crc_q
);
   if (WORD_W != CRC_MAX_W) begin : g_bad_width
      $error("crcru_crc_engine: WORD_W must equal 32");
   end

   int unsigned   nbits, pw;
   logic [31:0]   pv, mk, crc_upd;

   always_comb begin
      nbits   = size_bits(size);
      pw      = poly_width(poly);
      pv      = poly_value(poly);
      mk      = width_mask(pw);
      crc_upd = crc_q;
      for (int i = 0; i < WORD_W; i++) begin
         if (i < int'(nbits)) begin
            if (crc_upd[pw - 1] ^ data[int'(nbits) - 1 - i])
               crc_upd = ((crc_upd << 1) & mk) ^ pv;
            else
               crc_upd = (crc_upd << 1) & mk;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= RESET_SEED;
      else if (load)   crc_q <= load_val;
      else if (accept) crc_q <= crc_upd;
   end

   p_load_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (crc_q == $past(load_val)));

   p_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !load) |=> $stable(crc_q));

   p_crc8_narrow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !load && poly == 2'd0) |=> (crc_q[31:8] == 24'd0));

endmodule

// File: rtl/crc_reorder_unit.sv
module crc_reorder_unit
   import crcru_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter logic [31:0] RESET_SEED = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic [1:0]        in_size,
   input  logic [1:0]        cfg_poly,
   input  logic              cfg_crc_rev,
   input  logic              cfg_invert,
   input  logic [1:0]        cfg_bitrev,
   input  logic [1:0]        cfg_swap,
   input  logic [1:0]        cfg_par_range,
   input  logic              seed_wr,
   input  logic [31:0]       seed_data,
   input  logic              crc_init,
   output logic [WORD_W-1:0] out_data,
   output logic              out_parity,
   output logic [31:0]       crc_out
);
   if (WORD_W != CRC_MAX_W) begin : g_bad_width
      $error("crc_reorder_unit: WORD_W must equal 32");
   end

   logic [31:0]       seed_q;
   logic [31:0]       crc_q;
   logic [WORD_W-1:0] reord;
   logic              par_c;
   logic              load;
   logic [31:0]       load_val;

   assign in_ready = 1'b1;
   assign load     = seed_wr | crc_init;
   assign load_val = seed_wr ? seed_data : seed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seed_q <= RESET_SEED;
      else if (seed_wr) seed_q <= seed_data;
   end

   crcru_reorder #(.WORD_W(WORD_W)) u_reorder (
      .din    (in_data),
      .invert (cfg_invert),
      .bitrev (cfg_bitrev),
      .swap   (cfg_swap),
      .dout   (reord)
   );

   crcru_parity #(.WORD_W(WORD_W)) u_parity (
      .din       (in_data),
      .range_sel (cfg_par_range),
      .par       (par_c)
   );

   crcru_crc_engine #(.WORD_W(WORD_W), .RESET_SEED(RESET_SEED)) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (in_valid),
      .data     (in_data),
      .size     (in_size),
      .poly     (cfg_poly),
      .load     (load),
      .load_val (load_val),
      .crc_q    (crc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data   <= '0;
         out_parity <= 1'b0;
      end else if (in_valid) begin
         out_data   <= reord;
         out_parity <= par_c;
      end
   end

   int unsigned pw;
   logic [31:0] crc_m, crc_rv;

   for (genvar i = 0; i < 32; i++) begin : g_crc_rev
      assign crc_rv[i] = crc_m[31 - i];
   end

   always_comb begin
      pw      = poly_width(cfg_poly);
      crc_m   = crc_q & width_mask(pw);
      crc_out = cfg_crc_rev ? (crc_rv >> (32 - pw)) : crc_m;
   end

   p_out_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_parity)));

   p_init_load_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (crc_init && !seed_wr) |=> (crc_q == $past(seed_q)));

   p_seed_store_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      seed_wr |=> (seed_q == $past(seed_data)));

endmodule

// File: tb/tb_crc_reorder_unit.sv
module tb_crc_reorder_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [31:0] in_data;
   logic [1:0]  in_size;
   logic [1:0]  cfg_poly;
   logic        cfg_crc_rev;
   logic        cfg_invert;
   logic [1:0]  cfg_bitrev;
   logic [1:0]  cfg_swap;
   logic [1:0]  cfg_par_range;
   logic        seed_wr;
   logic [31:0] seed_data;
   logic        crc_init;
   logic [31:0] out_data;
   logic        out_parity;
   logic [31:0] crc_out;

   int checks = 0;
   int errs   = 0;
   bit done   = 0;

   logic [31:0] m_seed, m_crc, m_out;
   logic        m_par;

   always #4 clk = ~clk;

   crc_reorder_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_size(in_size), .cfg_poly(cfg_poly),
      .cfg_crc_rev(cfg_crc_rev), .cfg_invert(cfg_invert), .cfg_bitrev(cfg_bitrev),
      .cfg_swap(cfg_swap), .cfg_par_range(cfg_par_range), .seed_wr(seed_wr),
      .seed_data(seed_data), .crc_init(crc_init), .out_data(out_data),
      .out_parity(out_parity), .crc_out(crc_out)
   );

   function automatic int f_width(input logic [1:0] p);
      return (p == 2'd0) ? 8 : (p == 2'd3) ? 32 : 16;
   endfunction

   function automatic logic [31:0] f_gen(input logic [1:0] p);
      case (p)
         2'd0:    return 32'h07;
         2'd1:    return 32'h8005;
         2'd2:    return 32'h1021;
         default: return 32'h04C11DB7;
      endcase
   endfunction

   function automatic logic [31:0] f_crc(input logic [31:0] c, input logic [31:0] d,
                                         input logic [1:0] sz, input logic [1:0] p);
      int w = f_width(p);
      int n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      logic [31:0] r = c;
      for (int b = n - 1; b >= 0; b--) begin
         logic top = r[w-1];
         for (int k = 31; k > 0; k--) r[k] = (k < w) ? r[k-1] : 1'b0;
         r[0] = 1'b0;
         if (top ^ d[b]) r = r ^ f_gen(p);
      end
      return r;
   endfunction

   function automatic logic [31:0] f_fmt(input logic [31:0] c, input logic [1:0] p,
                                         input logic rv);
      int w = f_width(p);
      logic [31:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = rv ? c[w-1-i] : c[i];
      return r;
   endfunction

   function automatic logic [31:0] f_reorder(input logic [31:0] d, input logic inv,
                                             input logic [1:0] rv, input logic [1:0] sw);
      logic [31:0] a = inv ? ~d : d;
      logic [31:0] b, c;
      int g = (rv == 2'd1) ? 8 : (rv == 2'd2) ? 16 : 32;
      for (int i = 0; i < 32; i++)
         b[i] = (rv == 2'd0) ? a[i] : a[(i / g) * g + (g - 1 - (i % g))];
      for (int k = 0; k < 4; k++) begin
         int src = (sw == 2'd1) ? (k ^ 1) : (sw == 2'd2) ? (3 - k) : k;
         c[k*8 +: 8] = b[src*8 +: 8];
      end
      return c;
   endfunction

   function automatic logic f_par(input logic [31:0] d, input logic [1:0] r);
      int n = (r == 2'd0) ? 8 : (r == 2'd1) ? 16 : 32;
      logic x = 1'b0;
      for (int i = 0; i < n; i++) x ^= d[i];
      return x;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Applies current inputs for one edge, updates the model, checks at the next negedge.
   task automatic step(input bit full);
      if (seed_wr) begin
         m_seed = seed_data;
         m_crc  = seed_data;
      end else if (crc_init) begin
         m_crc = m_seed;
      end else if (in_valid) begin
         m_crc = f_crc(m_crc, in_data, in_size, cfg_poly);
      end
      if (in_valid) begin
         m_out = f_reorder(in_data, cfg_invert, cfg_bitrev, cfg_swap);
         m_par = f_par(in_data, cfg_par_range);
      end
      @(negedge clk);
      if (full) begin
         chk("R3/R6 crc_out", crc_out, f_fmt(m_crc, cfg_poly, cfg_crc_rev));
         chk("R7/R8 out_data", out_data, m_out);
         chk("R9 out_parity", {31'd0, out_parity}, {31'd0, m_par});
         chk("R2 in_ready", {31'd0, in_ready}, 32'd1);
      end
   endtask

   task automatic idle();
      in_valid = 0; seed_wr = 0; crc_init = 0;
   endtask

   task automatic feed(input logic [31:0] d, input logic [1:0] sz);
      in_valid = 1; in_data = d; in_size = sz;
      step(1);
      in_valid = 0;
   endtask

   task automatic seed(input logic [31:0] s);
      seed_wr = 1; seed_data = s;
      step(1);
      seed_wr = 0;
   endtask

   task automatic feed_msg(input logic [1:0] p);
      cfg_poly = p;
      for (int i = 0; i < 9; i++) feed(32'h31 + i, 2'd0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [31:0] saved;
      rst_n = 0; idle();
      in_data = 0; in_size = 0; cfg_poly = 2'd3; cfg_crc_rev = 0; cfg_invert = 0;
      cfg_bitrev = 0; cfg_swap = 0; cfg_par_range = 0; seed_data = 0;
      m_seed = 32'hFFFF_FFFF; m_crc = 32'hFFFF_FFFF; m_out = 0; m_par = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, also under an active input
      in_valid = 1; in_data = 32'hA5A5_0001;
      @(negedge clk);
      chk("R1 crc_out", crc_out, 32'hFFFF_FFFF);
      chk("R1 out_data", out_data, 32'h0);
      chk("R1 out_parity", {31'd0, out_parity}, 32'd0);
      chk("R2 in_ready in reset", {31'd0, in_ready}, 32'd1);
      in_valid = 0;
      rst_n = 1;
      step(1);

      // R3: known check values, byte-wise
      seed(32'hFFFF_FFFF); feed_msg(2'd3);
      chk("R3 crc32 check", crc_out, 32'h0376E6E7);
      seed(32'h0000_FFFF); feed_msg(2'd2);
      chk("R3 ccitt check", crc_out, 32'h0000_29B1);
      cfg_crc_rev = 1; step(1);
      chk("R6 reversed ccitt", crc_out, 32'h0000_8D94);
      cfg_crc_rev = 0;
      seed(32'h0000_0000); feed_msg(2'd0);
      chk("R3 crc8 check", crc_out, 32'h0000_00F4);

      // R3: word sizes give the same crc as single bytes
      cfg_poly = 2'd3; seed(32'hFFFF_FFFF);
      feed(32'h31323334, 2'd2); feed(32'h35363738, 2'd3); feed(32'h00000039, 2'd0);
      chk("R3 crc32 word sizes", crc_out, 32'h0376E6E7);

      // R6: masking above the width
      cfg_poly = 2'd0; seed(32'hDEAD_BE5A); step(1);
      chk("R6 crc8 masked", crc_out, 32'h0000_005A);

      // R5: init reloads seed, word in the same cycle ignored by crc
      cfg_poly = 2'd1; seed(32'h0000_1234);
      feed(32'h0000_BEEF, 2'd1);
      crc_init = 1; in_valid = 1; in_data = 32'h0000_7777; in_size = 2'd1;
      step(1); crc_init = 0; in_valid = 0;
      chk("R5 init reload", crc_out, 32'h0000_1234);

      // R4: seed write beats init and data
      seed_wr = 1; crc_init = 1; in_valid = 1; seed_data = 32'h0000_4321;
      step(1); idle();
      chk("R4 seed priority", crc_out, 32'h0000_4321);

      // R7/R8 directed reorder
      cfg_bitrev = 2'd1; feed(32'h12345678, 2'd2);
      chk("R7 rev per byte", out_data, 32'h482C6A1E);
      cfg_bitrev = 2'd2; feed(32'h12345678, 2'd2);
      chk("R7 rev per half", out_data, 32'h2C481E6A);
      cfg_bitrev = 2'd3; feed(32'h12345678, 2'd2);
      chk("R7 rev word", out_data, 32'h1E6A2C48);
      cfg_bitrev = 2'd0; cfg_invert = 1; feed(32'h12345678, 2'd2);
      chk("R7 invert", out_data, 32'hEDCBA987);
      cfg_invert = 0; cfg_swap = 2'd1; feed(32'h12345678, 2'd2);
      chk("R8 swap halves", out_data, 32'h34127856);
      cfg_swap = 2'd2; feed(32'h12345678, 2'd2);
      chk("R8 swap word", out_data, 32'h78563412);
      cfg_swap = 2'd3; feed(32'h12345678, 2'd2);
      chk("R8 swap code 3 none", out_data, 32'h12345678);
      cfg_swap = 2'd0;

      // R9 parity ranges
      cfg_par_range = 2'd0; feed(32'h0000_0100, 2'd2);
      chk("R9 range8 excludes bit8", {31'd0, out_parity}, 32'd0);
      cfg_par_range = 2'd1; feed(32'h0000_0100, 2'd2);
      chk("R9 range16", {31'd0, out_parity}, 32'd1);
      feed(32'h0001_0000, 2'd2);
      chk("R9 range16 excludes bit16", {31'd0, out_parity}, 32'd0);
      cfg_par_range = 2'd2; feed(32'h8001_0000, 2'd2);
      chk("R9 range32", {31'd0, out_parity}, 32'd0);
      cfg_par_range = 2'd3; feed(32'h8000_0000, 2'd2);
      chk("R9 range32 code 3", {31'd0, out_parity}, 32'd1);

      // R10: holds with valid low while data changes
      saved = crc_out;
      in_data = 32'hFFFF_0000; cfg_invert = 1; step(1); step(1);
      chk("R10 out_data hold", out_data, 32'h8000_0000);
      chk("R10 crc hold", crc_out, saved);
      cfg_invert = 0;

      // random mix
      void'($urandom(32'd20250611));
      for (int n = 0; n < 3000; n++) begin
         in_valid      = ($urandom % 4) != 0;
         in_data       = $urandom;
         in_size       = 2'($urandom);
         cfg_poly      = 2'($urandom);
         cfg_crc_rev   = 1'($urandom);
         cfg_invert    = 1'($urandom);
         cfg_bitrev    = 2'($urandom);
         cfg_swap      = 2'($urandom);
         cfg_par_range = 2'($urandom);
         seed_wr       = ($urandom % 20) == 0;
         seed_data     = $urandom;
         crc_init      = ($urandom % 20) == 0;
         step(1);
      end
      idle();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
   end

endmodule